// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Split Parking and Tenure Cap

This block decides which of several bus masters owns a shared 32-bit AHB segment. Requests are served in rotating order, so that every requesting master eventually gets the bus. A master whose transfer the slave answered with SPLIT is taken out of contention until the slave raises that master's bit on HSPLIT. Other masters use the bus while it waits.

Ownership is counted in beats. Once the owner has moved the maximum number of beats allowed for one tenure, the bus is re-arbitrated. Grants are registered and change only on a clock edge where HREADY is high. With no eligible requester, the grant stays with the last owner. The address and data multiplexers and the slave decoder sit outside this block and take the grant and HMASTER outputs.

Top module: `ahb_rr_split_arbiter`

## Requirements
- R1: `grant` is one-hot at all times and `hmaster` holds the index of the granted master. After reset, master 0 owns the bus (`grant` = 3'b001, `hmaster` = 0).
- R2: When a tenure ends, the new owner is the first eligible requester found by scanning upward from the index after the current owner, with wrap-around. The current owner is considered last. Eligible means `req` is high and the master is not split-masked.
- R3: A beat is a cycle with `hready` high, the owner's `req` high and the owner not masked. After `MAX_BEATS` (default 8) beats the tenure ends and arbitration runs again.
- R4: A tenure ends on any `hready`-high cycle in which the owner's `req` is low.
- R5: `grant` and `hmaster` change only on a clock edge where `hready` was high in the preceding cycle.
- R6: `hresp` = 2'b11 (SPLIT) with `hready` high masks the current owner and ends its tenure at that same edge. All other `hresp` codes (00 OKAY, 01 ERROR, 10 RETRY) have no effect on arbitration.
- R7: A masked master is never newly granted, even if it is the only requester.
- R8: `hsplit[i]` high clears the mask of master i, and master i is eligible in the arbitration at that same edge. If one master gets both a SPLIT and its `hsplit` bit in the same cycle, the SPLIT wins and the master stays masked.
- R9: When no master is eligible at the end of a tenure, the grant stays on the most recent owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_MST | Request line of each master |
| hready | input | 1 | Transfer-complete indication from the slave |
| hresp | input | 2 | Slave response; 2'b11 means SPLIT |
| hsplit | input | NUM_MST | Split-resume bits from the slave, one per master |
| grant | output | NUM_MST | One-hot bus grant |
| hmaster | output | $clog2(NUM_MST) | Index of the current owner |

## Verification
The bench targets these corners:
- **Beat cap while others wait.** A master that holds the bus past eight beats would show up as a grant that never leaves it.
- **SPLIT and resume in the same cycle.** Letting the resume win would hand the bus straight back to a master that has nothing to transfer.
- **Masked master as the only requester.** Granting it would show the mask being bypassed. Dropping the grant to another master would break parking.
- **HREADY low during a request change.** A design that re-arbitrates in that cycle would move the grant mid-transfer.

Each of these faults diverges from the reference model within a cycle or two.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [1:0] {
      RESP_OKAY  = 2'b00,
      RESP_ERROR = 2'b01,
      RESP_RETRY = 2'b10,
      RESP_SPLIT = 2'b11
   } resp_e;
endpackage

// File: rtl/split_mask.sv
module split_mask #(
   parameter int NUM_MST = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_MST-1:0] park_vec,
   input  logic [NUM_MST-1:0] wake_vec,
   output logic [NUM_MST-1:0] mask_q,
   output logic [NUM_MST-1:0] mask_nxt
);
   // A new split overrides a resume arriving in the same cycle.
   assign mask_nxt = (mask_q & ~wake_vec) | park_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_nxt;
   end
endmodule

// File: rtl/tenure_ctr.sv
module tenure_ctr #(
   parameter int MAX_BEATS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hready,
   input  logic beat,
   input  logic force_end,
   output logic tenure_end
);
   localparam int CW = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

   logic [CW-1:0] cnt_q;
   logic          last_beat;

   assign last_beat  = beat && (cnt_q == CW'(MAX_BEATS - 1));
   assign tenure_end = hready && (force_end || last_beat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (tenure_end) cnt_q <= '0;
      else if (beat)       cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int NUM_MST = 3
) (
   input  logic [NUM_MST-1:0]         elig,
   input  logic [$clog2(NUM_MST)-1:0] last_idx,
   output logic                       found,
   output logic [$clog2(NUM_MST)-1:0] win_idx
);
   localparam int  IDW  = $clog2(NUM_MST);
   localparam bit  POW2 = (NUM_MST == (1 << IDW));

   logic [IDW-1:0] cand [NUM_MST];

   generate
      if (POW2) begin : g_wrap_trunc
         for (genvar k = 0; k < NUM_MST; k++) begin : g_off
            assign cand[k] = last_idx + IDW'(k + 1);
         end
      end else begin : g_wrap_sub
         for (genvar k = 0; k < NUM_MST; k++) begin : g_off
            logic [IDW:0] sum;
            assign sum     = {1'b0, last_idx} + (IDW+1)'(k + 1);
            assign cand[k] = (sum >= (IDW+1)'(NUM_MST)) ?
                             IDW'(sum - (IDW+1)'(NUM_MST)) : sum[IDW-1:0];
         end
      end
   endgenerate

   // Nearest offset wins: scan far to near, later hits overwrite.
   always_comb begin
      found   = 1'b0;
      win_idx = last_idx;
      for (int k = NUM_MST - 1; k >= 0; k--) begin
         if (elig[cand[k]]) begin
            found   = 1'b1;
            win_idx = cand[k];
         end
      end
   end
endmodule

// File: rtl/ahb_rr_split_arbiter.sv
module ahb_rr_split_arbiter #(
   parameter int NUM_MST   = 3,
   parameter int MAX_BEATS = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_MST-1:0]         req,
   input  logic                       hready,
   input  logic [1:0]                 hresp,
   input  logic [NUM_MST-1:0]         hsplit,
   output logic [NUM_MST-1:0]         grant,
   output logic [$clog2(NUM_MST)-1:0] hmaster
);
   import arb_pkg::*;

   localparam int IDW = $clog2(NUM_MST);

   generate
      if (NUM_MST < 2) begin : g_bad_nmst
         $error("NUM_MST must be at least 2");
      end
      if (MAX_BEATS < 1) begin : g_bad_beats
         $error("MAX_BEATS must be at least 1");
      end
   endgenerate

   logic [IDW-1:0]     owner_q;
   logic [NUM_MST-1:0] owner_oh;
   logic [NUM_MST-1:0] mask_q, mask_nxt, park_vec;
   logic [NUM_MST-1:0] elig;
   logic [IDW-1:0]     win_idx;
   logic               found, split_now, own_req, own_masked;
   logic               beat, force_end, tenure_end;

   assign owner_oh   = {{(NUM_MST-1){1'b0}}, 1'b1} << owner_q;
   assign split_now  = hready && (hresp == RESP_SPLIT);
   assign park_vec   = split_now ? owner_oh : '0;
   assign own_req    = req[owner_q];
   assign own_masked = mask_q[owner_q];
   assign beat       = hready && own_req && !own_masked;
   assign force_end  = !own_req || split_now || own_masked;
   assign elig       = req & ~mask_nxt;

   split_mask #(.NUM_MST(NUM_MST)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .park_vec (park_vec),
      .wake_vec (hsplit),
      .mask_q   (mask_q),
      .mask_nxt (mask_nxt)
   );

   tenure_ctr #(.MAX_BEATS(MAX_BEATS)) u_tenure (
      .clk        (clk),
      .rst_n      (rst_n),
      .hready     (hready),
      .beat       (beat),
      .force_end  (force_end),
      .tenure_end (tenure_end)
   );

   rr_pick #(.NUM_MST(NUM_MST)) u_pick (
      .elig     (elig),
      .last_idx (owner_q),
      .found    (found),
      .win_idx  (win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  owner_q <= '0;
      else if (tenure_end && found) owner_q <= win_idx;
   end

   assign grant   = owner_oh;
   assign hmaster = owner_q;
endmodule

// File: rtl/ahb_rr_split_arbiter_chk.sv
module ahb_rr_split_arbiter_chk #(
   parameter int NUM_MST   = 3,
   parameter int MAX_BEATS = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_MST-1:0]         req,
   input logic                       hready,
   input logic [1:0]                 hresp,
   input logic [NUM_MST-1:0]         hsplit,
   input logic [NUM_MST-1:0]         grant,
   input logic [$clog2(NUM_MST)-1:0] hmaster
);
   logic [NUM_MST-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else begin
         pend_q <= pend_q & ~hsplit;
         if (hready && hresp == 2'b11) pend_q[hmaster] <= 1'b1;
      end
   end

   // R1
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant) == 1);

   // R1
   hmaster_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant[hmaster]);

   // R5
   hold_when_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hready |=> $stable(grant) && $stable(hmaster));

   // R7
   no_masked_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hmaster != $past(hmaster)) |-> !pend_q[hmaster]);

   // R9
   park_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && req == '0) |=> $stable(hmaster));

   logic unused_ok;
   assign unused_ok = (MAX_BEATS > 0);
endmodule

bind ahb_rr_split_arbiter ahb_rr_split_arbiter_chk #(
   .NUM_MST   (NUM_MST),
   .MAX_BEATS (MAX_BEATS)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .req     (req),
   .hready  (hready),
   .hresp   (hresp),
   .hsplit  (hsplit),
   .grant   (grant),
   .hmaster (hmaster)
);

// File: tb/ahb_rr_split_arbiter_tb_top.sv
`timescale 1ns/1ps
module ahb_rr_split_arbiter_tb_top;
   localparam int N    = 3;
   localparam int MAXB = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         hready = 1'b1;
   logic [1:0]   hresp = 2'b00;
   logic [N-1:0] hsplit = '0;
   logic [N-1:0] grant;
   logic [1:0]   hmaster;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   bit    live = 1'b0;
   string tag = "R1";

   int     m_own;
   bit [N-1:0] m_mask;
   int     m_cnt;

   always #2.5 clk = ~clk;

   ahb_rr_split_arbiter #(.NUM_MST(N), .MAX_BEATS(MAXB)) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .hready(hready),
      .hresp(hresp), .hsplit(hsplit), .grant(grant), .hmaster(hmaster)
   );

   // Behavioural reference
   always @(posedge clk) begin
      if (!rst_n) begin
         m_own = 0; m_mask = '0; m_cnt = 0;
      end else begin
         bit sp, bt, fin;
         bit [N-1:0] mn;
         int nw, c;
         sp = hready && (hresp == 2'b11);
         bt = hready && req[m_own] && !m_mask[m_own];
         mn = m_mask & ~hsplit;
         if (sp) mn[m_own] = 1'b1;
         fin = hready && (!req[m_own] || sp || m_mask[m_own] ||
                          (bt && m_cnt == MAXB - 1));
         if (fin) begin
            m_cnt = 0;
            nw = m_own;
            for (int k = N; k >= 1; k--) begin
               c = (m_own + k) % N;
               if (req[c] && !mn[c]) nw = c;
            end
            m_own = nw;
         end else if (bt) begin
            m_cnt = m_cnt + 1;
         end
         m_mask = mn;
      end
   end

   // Compare every cycle away from the active edge
   always @(negedge clk) begin
      if (live && !done) begin
         bit [N-1:0] eg;
         eg = '0;
         eg[m_own] = 1'b1;
         n_cmp++;
         if (grant !== eg || hmaster !== 2'(m_own)) begin
            n_bad++;
            $display("FAIL %s: grant=%b hmaster=%0d expected grant=%b hmaster=%0d",
                     tag, grant, hmaster, eg, m_own);
         end
      end
   end

   task automatic drive(input logic [N-1:0] r, input logic hr,
                        input logic [1:0] rs, input logic [N-1:0] hs,
                        input int cyc, input string t);
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         #0.5;
         tag = t; req = r; hready = hr; hresp = rs; hsplit = hs;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      n_cmp++;
      if (grant !== 3'b001 || hmaster !== 2'd0) begin
         n_bad++;
         $display("FAIL R1: reset grant=%b hmaster=%0d expected 001/0", grant, hmaster);
      end
      live = 1'b1;
      // R2/R3: all masters request, bus always ready -> rotation every 8 beats
      drive(3'b111, 1'b1, 2'b00, 3'b000, 40, "R3");
      // R2: sparse requesters, rotation skips idle master
      drive(3'b101, 1'b1, 2'b00, 3'b000, 20, "R2");
      // R4: owner drops request mid-tenure
      drive(3'b110, 1'b1, 2'b00, 3'b000, 3, "R4");
      drive(3'b100, 1'b1, 2'b00, 3'b000, 2, "R4");
      drive(3'b011, 1'b1, 2'b00, 3'b000, 4, "R4");
      // R5: wait states while requests change
      drive(3'b100, 1'b0, 2'b00, 3'b000, 4, "R5");
      drive(3'b010, 1'b0, 2'b00, 3'b000, 3, "R5");
      drive(3'b010, 1'b1, 2'b00, 3'b000, 3, "R5");
      // R6: split on owner, other codes ignored
      drive(3'b111, 1'b1, 2'b01, 3'b000, 2, "R6");
      drive(3'b111, 1'b1, 2'b10, 3'b000, 2, "R6");
      drive(3'b111, 1'b1, 2'b11, 3'b000, 1, "R6");
      drive(3'b111, 1'b1, 2'b00, 3'b000, 20, "R6");
      // R7: masked master alone requesting is not granted
      drive(3'b111, 1'b1, 2'b11, 3'b000, 1, "R7");
      drive(3'b111, 1'b1, 2'b11, 3'b000, 1, "R7");
      drive(3'b111, 1'b1, 2'b11, 3'b000, 1, "R7");
      drive(3'b111, 1'b1, 2'b00, 3'b000, 6, "R7");
      // R8: release one at a time; same-cycle split beats resume
      drive(3'b111, 1'b1, 2'b00, 3'b001, 1, "R8");
      drive(3'b111, 1'b1, 2'b00, 3'b000, 5, "R8");
      drive(3'b111, 1'b1, 2'b11, 3'b111, 1, "R8");
      drive(3'b111, 1'b1, 2'b00, 3'b000, 12, "R8");
      drive(3'b111, 1'b1, 2'b00, 3'b111, 1, "R8");
      // R9: nobody requesting -> park
      drive(3'b000, 1'b1, 2'b00, 3'b000, 6, "R9");
      drive(3'b000, 1'b0, 2'b00, 3'b000, 2, "R9");
      // R2: random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [N-1:0] r, hs;
         logic hr;
         logic [1:0] rs;
         r  = N'($urandom_range(0, 7));
         hr = ($urandom_range(0, 3) != 0);
         rs = ($urandom_range(0, 15) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
         hs = '0;
         for (int b = 0; b < N; b++) hs[b] = ($urandom_range(0, 7) == 0);
         drive(r, hr, rs, hs, 1, "R2");
      end
      drive(3'b000, 1'b1, 2'b00, 3'b000, 3, "R9");
      finish_run();
   end
endmodule